// File: doc/BRIEF.md
# CPU Privilege Mode and Mapping Control

This block keeps the privilege state of a 16-bit minicomputer-style processor. It holds a small control register that the kernel uses to turn address mapping on, to unplug the boot ROM overlay, and to ask for a drop into user mode. It also drives the current and previous mode fields of the status word. The processor core reports three kinds of event to the block: a return-from-interrupt, an interrupt acknowledge together with a kernel-force line, and a software interrupt. The block applies the mode changes that these events call for.

A request for user mode takes no effect until the next return-from-interrupt, so the kernel can finish setting up its frame first. An interrupt acknowledge with the kernel-force line held low, or any software interrupt, puts the processor back in kernel mode. The block keeps one stack pointer per mode and shows both the current one and the previous-mode one, so the core can fetch the other mode's stack. A user-mode attempt to reach the control register has no effect and raises a trap request toward vector 4.

Top module: `cpu_mode_ctl`

## Requirements
- R1: After reset the mode is kernel, `psw_mode` is 4'b0000, `user_mode` is 0, `map_en` is 0, `shadow_en` is 1, and a kernel read of the control register returns 16'h0001.
- R2: A kernel write to the control register loads bit 0 (boot ROM overlay at physical 0100000), bit 1 (mapping enable) and bit 2 (user-mode request). A read returns those bits in the same positions, and bit 3 (current mode) and bits 15:4 read as 0.
- R3: Setting the request bit leaves the mode unchanged. In the cycle after `rti_exec` is seen in kernel mode with the request set, `psw_mode` becomes 4'b1100 (current user 11, previous kernel 00) and the request bit reads back 0.
- R4: `rti_exec` with the request bit clear leaves the mode unchanged.
- R5: `iack` with `kern_force_n` low gives kernel mode on the next cycle, with the previous field holding the mode that was active before (4'b0011 from user). `iack` with `kern_force_n` high has no effect.
- R6: `swi_exec` gives kernel mode on the next cycle, with the previous field loaded as in R5.
- R7: A control register read or write in user mode asserts `trap_req` for one cycle, on the cycle after the access. The write has no effect and the read returns 0. Kernel accesses never raise `trap_req`. `trap_vec` is 4.
- R8: `sp_wr` writes the stack pointer of the current mode. `sp_rdata` shows the current mode's stack pointer and `sp_prev_rdata` shows the previous mode's. All other registers are shared, so the block holds none of them.
- R9: When a kernel entry (R5 or R6) and `rti_exec` happen in the same cycle, the kernel entry wins and the request bit stays set.
- R10: `map_en` and `shadow_en` follow the control register bits from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_sel | input | 1 | Control register addressed |
| ctl_wr | input | 1 | Write strobe |
| ctl_rd | input | 1 | Read strobe |
| ctl_wdata | input | 16 | Write data |
| ctl_rdata | output | 16 | Read data (combinational) |
| trap_req | output | 1 | Access-violation trap request |
| trap_vec | output | 8 | Trap vector number (4) |
| rti_exec | input | 1 | Return-from-interrupt executing |
| iack | input | 1 | Interrupt acknowledge cycle |
| kern_force_n | input | 1 | Low during `iack` forces kernel mode |
| swi_exec | input | 1 | Software interrupt executing |
| psw_mode | output | 4 | Status word bits 15:12 (current, previous) |
| user_mode | output | 1 | Current mode is user |
| map_en | output | 1 | Address mapping enabled |
| shadow_en | output | 1 | Boot ROM overlay active |
| sp_wr | input | 1 | Write current stack pointer |
| sp_wdata | input | 16 | Stack pointer write data |
| sp_rdata | output | 16 | Current-mode stack pointer |
| sp_prev_rdata | output | 16 | Previous-mode stack pointer |

## Verification
The bench checks that a request alone does not switch the mode. A design that switched at once would show user mode before the return-from-interrupt. It checks that the request self-clears, which a faulty design would miss by switching again on a later return. A user-mode write to the register must leave it untouched, and a leaky design would change the mapping bits. A same-cycle software interrupt and return must end in kernel mode with the request still pending. The stack-pointer checks catch a design that writes the wrong mode's stack pointer or swaps the previous-mode view.

// File: rtl/cpu_mode_pkg.sv
package cpu_mode_pkg;
  typedef enum logic [1:0] {
    MODE_KERN = 2'b00,
    MODE_USER = 2'b11
  } cpu_mode_e;

  localparam int CTL_SHADOW_BIT = 0;
  localparam int CTL_MAP_BIT    = 1;
  localparam int CTL_REQ_BIT    = 2;
  localparam int CTL_CUR_BIT    = 3;

  typedef struct packed {
    logic req;
    logic map_en;
    logic shadow;
  } ctl_bits_t;
endpackage

// File: rtl/mmu_ctl_reg.sv
module mmu_ctl_reg
  import cpu_mode_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_user,
  input  logic              sel,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr_req,
  output logic [DATA_W-1:0] rdata,
  output ctl_bits_t         ctl,
  output logic              trap_req
);
  logic kern_wr;
  logic user_touch;

  assign kern_wr    = !in_user && sel && wr;
  assign user_touch = in_user && sel && (wr || rd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl.req    <= 1'b0;
      ctl.map_en <= 1'b0;
      ctl.shadow <= 1'b1;
      trap_req   <= 1'b0;
    end else begin
      trap_req <= user_touch;
      if (clr_req) ctl.req <= 1'b0;
      if (kern_wr) begin
        ctl.req    <= wdata[CTL_REQ_BIT];
        ctl.map_en <= wdata[CTL_MAP_BIT];
        ctl.shadow <= wdata[CTL_SHADOW_BIT];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (!in_user && sel && rd) begin
      rdata[CTL_SHADOW_BIT] = ctl.shadow;
      rdata[CTL_MAP_BIT]    = ctl.map_en;
      rdata[CTL_REQ_BIT]    = ctl.req;
      rdata[CTL_CUR_BIT]    = 1'b0;
    end
  end
endmodule

// File: rtl/mode_seq.sv
module mode_seq
  import cpu_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rti_exec,
  input  logic      req,
  input  logic      iack,
  input  logic      kern_force_n,
  input  logic      swi_exec,
  output cpu_mode_e cur,
  output cpu_mode_e prev,
  output logic      req_taken
);
  logic entry;
  logic to_user;

  assign entry     = (iack && !kern_force_n) || swi_exec;
  assign to_user   = rti_exec && req && (cur == MODE_KERN) && !entry;
  assign req_taken = to_user;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur  <= MODE_KERN;
      prev <= MODE_KERN;
    end else if (entry) begin
      prev <= cur;
      cur  <= MODE_KERN;
    end else if (to_user) begin
      prev <= cur;
      cur  <= MODE_USER;
    end
  end
endmodule

// File: rtl/sp_bank.sv
module sp_bank #(
  parameter int SP_W    = 16,
  parameter int N_MODES = 2,
  localparam int IDX_W  = (N_MODES > 1) ? $clog2(N_MODES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic [IDX_W-1:0] prev_idx,
  input  logic             wr,
  input  logic [SP_W-1:0]  wdata,
  output logic [SP_W-1:0]  rdata,
  output logic [SP_W-1:0]  prev_rdata
);
  logic [SP_W-1:0] sp_all [N_MODES];

  for (genvar g = 0; g < N_MODES; g++) begin : g_sp
    logic [SP_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (wr && (cur_idx == IDX_W'(g))) q <= wdata;
    end
    assign sp_all[g] = q;
  end

  assign rdata      = sp_all[cur_idx];
  assign prev_rdata = sp_all[prev_idx];
endmodule

// File: rtl/cpu_mode_ctl.sv
module cpu_mode_ctl
  import cpu_mode_pkg::*;
#(
  parameter int         DATA_W   = 16,
  parameter int         SP_W     = 16,
  parameter int         VEC_W    = 8,
  parameter logic [7:0] TRAP_NUM = 8'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_sel,
  input  logic              ctl_wr,
  input  logic              ctl_rd,
  input  logic [DATA_W-1:0] ctl_wdata,
  output logic [DATA_W-1:0] ctl_rdata,
  output logic              trap_req,
  output logic [VEC_W-1:0]  trap_vec,
  input  logic              rti_exec,
  input  logic              iack,
  input  logic              kern_force_n,
  input  logic              swi_exec,
  output logic [3:0]        psw_mode,
  output logic              user_mode,
  output logic              map_en,
  output logic              shadow_en,
  input  logic              sp_wr,
  input  logic [SP_W-1:0]   sp_wdata,
  output logic [SP_W-1:0]   sp_rdata,
  output logic [SP_W-1:0]   sp_prev_rdata
);
  localparam int N_MODES = 2;
  localparam int IDX_W   = 1;

  cpu_mode_e cur_mode, prev_mode;
  ctl_bits_t ctl;
  logic      req_taken;

  assign user_mode = (cur_mode == MODE_USER);

  mmu_ctl_reg #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .in_user(user_mode),
    .sel(ctl_sel), .wr(ctl_wr), .rd(ctl_rd), .wdata(ctl_wdata),
    .clr_req(req_taken), .rdata(ctl_rdata), .ctl(ctl), .trap_req(trap_req)
  );

  mode_seq u_seq (
    .clk(clk), .rst_n(rst_n), .rti_exec(rti_exec), .req(ctl.req),
    .iack(iack), .kern_force_n(kern_force_n), .swi_exec(swi_exec),
    .cur(cur_mode), .prev(prev_mode), .req_taken(req_taken)
  );

  sp_bank #(.SP_W(SP_W), .N_MODES(N_MODES)) u_sp (
    .clk(clk), .rst_n(rst_n),
    .cur_idx(IDX_W'(cur_mode == MODE_USER)),
    .prev_idx(IDX_W'(prev_mode == MODE_USER)),
    .wr(sp_wr), .wdata(sp_wdata),
    .rdata(sp_rdata), .prev_rdata(sp_prev_rdata)
  );

  assign psw_mode  = {cur_mode, prev_mode};
  assign map_en    = ctl.map_en;
  assign shadow_en = ctl.shadow;
  assign trap_vec  = VEC_W'(TRAP_NUM);
endmodule

// File: rtl/cpu_mode_ctl_chk.sv
module cpu_mode_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_sel,
  input logic        ctl_wr,
  input logic        ctl_rd,
  input logic [15:0] ctl_rdata,
  input logic        trap_req,
  input logic        rti_exec,
  input logic        iack,
  input logic        kern_force_n,
  input logic        swi_exec,
  input logic [3:0]  psw_mode,
  input logic        user_mode,
  input logic        map_en,
  input logic        shadow_en,
  input logic        sp_wr,
  input logic [15:0] sp_wdata,
  input logic [15:0] sp_rdata
);
  // R7
  user_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && ctl_sel && (ctl_wr || ctl_rd)) |=> trap_req);

  // R7
  kern_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!user_mode || !ctl_sel) |=> !trap_req);

  // R7
  user_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && ctl_sel && ctl_wr) |=> ($stable(map_en) && $stable(shadow_en)));

  // R5
  iack_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && !kern_force_n) |=> (psw_mode[3:2] == 2'b00));

  // R6
  swi_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swi_exec |=> (psw_mode[3:2] == 2'b00 && psw_mode[1:0] == $past(psw_mode[3:2])));

  // R4
  user_needs_rti_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!user_mode && !rti_exec) |=> !user_mode);

  // R2
  always @(posedge clk) begin
    if (rst_n) rdata_upper_chk: assert (ctl_rdata[15:3] == 13'd0);
  end

  // R8
  sp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_wr && !iack && !swi_exec && !rti_exec) |=> (sp_rdata == $past(sp_wdata)));
endmodule

bind cpu_mode_ctl cpu_mode_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_sel(ctl_sel), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
  .ctl_rdata(ctl_rdata), .trap_req(trap_req), .rti_exec(rti_exec), .iack(iack),
  .kern_force_n(kern_force_n), .swi_exec(swi_exec), .psw_mode(psw_mode),
  .user_mode(user_mode), .map_en(map_en), .shadow_en(shadow_en),
  .sp_wr(sp_wr), .sp_wdata(sp_wdata), .sp_rdata(sp_rdata)
);

// File: tb/tb_cpu_mode_ctl.sv
`timescale 1ns/1ps
module tb_cpu_mode_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_sel = 0, ctl_wr = 0, ctl_rd = 0;
  logic [15:0] ctl_wdata = '0;
  logic [15:0] ctl_rdata;
  logic        trap_req;
  logic [7:0]  trap_vec;
  logic        rti_exec = 0, iack = 0, kern_force_n = 1, swi_exec = 0;
  logic [3:0]  psw_mode;
  logic        user_mode, map_en, shadow_en;
  logic        sp_wr = 0;
  logic [15:0] sp_wdata = '0;
  logic [15:0] sp_rdata, sp_prev_rdata;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  cpu_mode_ctl dut (
    .clk(clk), .rst_n(rst_n), .ctl_sel(ctl_sel), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .trap_req(trap_req),
    .trap_vec(trap_vec), .rti_exec(rti_exec), .iack(iack),
    .kern_force_n(kern_force_n), .swi_exec(swi_exec), .psw_mode(psw_mode),
    .user_mode(user_mode), .map_en(map_en), .shadow_en(shadow_en),
    .sp_wr(sp_wr), .sp_wdata(sp_wdata), .sp_rdata(sp_rdata),
    .sp_prev_rdata(sp_prev_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ctl_write(input logic [15:0] d);
    ctl_sel = 1; ctl_wr = 1; ctl_wdata = d;
    step();
    ctl_sel = 0; ctl_wr = 0;
  endtask

  task automatic ctl_read(output logic [15:0] d);
    ctl_sel = 1; ctl_rd = 1;
    #1 d = ctl_rdata;
    step();
    ctl_sel = 0; ctl_rd = 0;
  endtask

  task automatic pulse_rti();
    rti_exec = 1; step(); rti_exec = 0;
  endtask

  task automatic pulse_swi();
    swi_exec = 1; step(); swi_exec = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 psw_mode", 32'(psw_mode), 32'h0);
    check("R1 user_mode", 32'(user_mode), 32'h0);
    check("R1 map_en", 32'(map_en), 32'h0);
    check("R1 shadow_en", 32'(shadow_en), 32'h1);
    ctl_read(d);
    check("R1 ctl read", 32'(d), 32'h0001);
  endtask

  task automatic t_write();
    logic [15:0] d;
    ctl_write(16'hFFFE);
    check("R10 map_en", 32'(map_en), 32'h1);
    check("R10 shadow_en", 32'(shadow_en), 32'h0);
    check("R7 no kernel trap", 32'(trap_req), 32'h0);
    ctl_read(d);
    check("R2 read bits, cur=0", 32'(d), 32'h0006);
    check("R3 request alone no switch", 32'(psw_mode), 32'h0);
    ctl_write(16'h0003);
    ctl_read(d);
    check("R2 read 0003", 32'(d), 32'h0003);
  endtask

  task automatic t_rti_noreq();
    pulse_rti();
    check("R4 rti without request", 32'(psw_mode), 32'h0);
  endtask

  task automatic t_to_user();
    logic [15:0] d;
    sp_wr = 1; sp_wdata = 16'h1234; step(); sp_wr = 0;
    check("R8 kernel sp", 32'(sp_rdata), 32'h1234);
    ctl_write(16'h0006);
    step();
    check("R3 still kernel", 32'(psw_mode), 32'h0);
    pulse_rti();
    check("R3 user after rti", 32'(psw_mode), 32'hC);
    check("R3 user_mode", 32'(user_mode), 32'h1);
    check("R8 user sp empty", 32'(sp_rdata), 32'h0);
    check("R8 prev sp kernel", 32'(sp_prev_rdata), 32'h1234);
    sp_wr = 1; sp_wdata = 16'hBEEF; step(); sp_wr = 0;
    check("R8 user sp written", 32'(sp_rdata), 32'hBEEF);
    check("R8 kernel sp kept", 32'(sp_prev_rdata), 32'h1234);
    ctl_sel = 1; ctl_wr = 1; ctl_wdata = 16'h0000;
    step();
    ctl_sel = 0; ctl_wr = 0;
    check("R7 trap on user write", 32'(trap_req), 32'h1);
    check("R7 trap vector", 32'(trap_vec), 32'h4);
    step();
    check("R7 trap one cycle", 32'(trap_req), 32'h0);
    ctl_read(d);
    check("R7 user read zero", 32'(d), 32'h0);
    check("R7 trap on user read", 32'(trap_req), 32'h1);
    check("R7 user write ignored map", 32'(map_en), 32'h1);
    iack = 1; kern_force_n = 1; step(); iack = 0;
    check("R5 iack line high no entry", 32'(psw_mode), 32'hC);
    iack = 1; kern_force_n = 0; step(); iack = 0; kern_force_n = 1;
    check("R5 iack entry", 32'(psw_mode), 32'h3);
    check("R8 sp back to kernel", 32'(sp_rdata), 32'h1234);
    check("R8 prev sp user", 32'(sp_prev_rdata), 32'hBEEF);
    ctl_read(d);
    check("R3 request self-cleared, R7 write ignored", 32'(d), 32'h0002);
    pulse_rti();
    check("R3 no second switch", 32'(psw_mode), 32'h3);
  endtask

  task automatic t_swi();
    ctl_write(16'h0006);
    pulse_rti();
    check("R3 user again", 32'(psw_mode), 32'hC);
    pulse_swi();
    check("R6 swi entry", 32'(psw_mode), 32'h3);
  endtask

  task automatic t_priority();
    logic [15:0] d;
    ctl_write(16'h0006);
    rti_exec = 1; swi_exec = 1; step(); rti_exec = 0; swi_exec = 0;
    check("R9 entry wins", 32'(psw_mode), 32'h0);
    ctl_read(d);
    check("R9 request kept", 32'(d), 32'h0006);
    pulse_rti();
    check("R9 pending request applied", 32'(psw_mode), 32'hC);
    pulse_swi();
    check("R6 return to kernel", 32'(psw_mode), 32'h3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write();
    t_rti_noreq();
    t_to_user();
    t_swi();
    t_priority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule